// File: doc/BRIEF.md
# Multithreaded Commit Thread Arbiter

In a processor that retires instructions from several hardware threads, each commit slot can serve only one thread. This block picks that thread. Every thread reports four things about the head of its reorder buffer: a commit status code, an empty flag, a head-ready flag and the sequence number of the head entry. A static policy input chooses how the winner is picked. The block answers with a valid flag and a thread index.

The oldest-first rule grants the eligible thread whose head instruction is oldest, which means the smallest sequence number. The aggressive setting uses the same rule. The round-robin rule walks an internal ordered list of threads. When the consumer accepts a round-robin grant, it pulses a take strobe, and the winner then moves to the back of the list. Selection is purely combinational on the current inputs and the list, so a caller can query the block again after each slot. When the block is built for a single thread, the selection reduces to a check of that thread's status.

Top module: `commit_arbiter`

## Requirements
- R1: Reset sets the round-robin list to ascending order 0, 1, ..., N-1. When every thread is eligible, the first round-robin grant after reset is thread 0.
- R2: Status codes are 0 Idle, 1 Running, 2 squashing, 3 trap pending, 4 fetch-trap pending. Codes 5 to 7 are never eligible. Under round-robin, a thread is eligible when its status is 0 or 1 and its head-ready flag is set. The empty flag is not consulted.
- R3: Under round-robin, the grant goes to the first eligible thread when the list is read from front to back.
- R4: When grant_take is high with a valid round-robin grant, the granted thread moves to the back of the list at the next clock edge. All other threads keep their relative order. Without grant_take the list does not change.
- R5: grant_take has no effect on the list while the policy is not round-robin.
- R6: Under the oldest-first rule, a thread is eligible when its empty flag is clear, its head-ready flag is set, and its status is 0, 1 or 4.
- R7: The oldest-first rule grants the eligible thread with the smallest head sequence number. Equal sequence numbers resolve to the lowest thread index.
- R8: Policy code 1 selects round-robin and code 2 selects oldest-first. Code 0 (aggressive) and the unused code 3 both select exactly as code 2 does.
- R9: When no thread is eligible under the active policy, grant_valid is 0 and grant_idx is 0.
- R10: With one thread configured, grant_valid is 1 exactly when that thread's status is 0, 1 or 4. This holds whatever the policy, ready, empty and sequence inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Selection rule: 0 aggressive, 1 round-robin, 2 oldest-first, 3 as 2 |
| thr_status | input | 3*NTHR | Per-thread status code, thread i at bits [3i+2:3i] |
| thr_empty | input | NTHR | Per-thread reorder buffer empty |
| thr_ready | input | NTHR | Per-thread head entry ready to retire |
| thr_seq | input | SEQW*NTHR | Per-thread head sequence number, thread i at [SEQW*i +: SEQW] |
| grant_take | input | 1 | Consumer accepts the current grant |
| grant_valid | output | 1 | A thread is granted |
| grant_idx | output | IDXW | Index of the granted thread |

## Verification
The bench goes after the places where the two eligibility rules differ. A design that shared a single rule would either let fetch-trap-pending threads win under round-robin or make round-robin depend on the empty flag. The bench also checks rotation after grants taken at every list position. A design that swapped the winner with the last entry, instead of shifting the entries behind it forward, would scramble later grants. Equal sequence numbers catch a design whose comparison favours the higher index. Strobes of grant_take under oldest-first are followed by round-robin queries, which expose a list that moved when it should not have. A second instance, built for one thread, sweeps every status code with ready held low.

// File: rtl/commit_arbiter.sv
module commit_arbiter #(
  parameter int NTHR = 4,
  parameter int SEQW = 8,
  localparam int IDXW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             policy,
  input  logic [3*NTHR-1:0]      thr_status,
  input  logic [NTHR-1:0]        thr_empty,
  input  logic [NTHR-1:0]        thr_ready,
  input  logic [SEQW*NTHR-1:0]   thr_seq,
  input  logic                   grant_take,
  output logic                   grant_valid,
  output logic [IDXW-1:0]        grant_idx
);
  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_RUN   = 3'd1;
  localparam logic [2:0] ST_FTRAP = 3'd4;
  localparam logic [1:0] POL_RR   = 2'd1;

  logic [NTHR-1:0] base_ok;
  logic [NTHR-1:0] rr_ok;
  logic [NTHR-1:0] old_ok;

  for (genvar i = 0; i < NTHR; i++) begin : g_elig
    logic [2:0] st;
    assign st        = thr_status[3*i +: 3];
    assign base_ok[i] = (st == ST_IDLE) || (st == ST_RUN);
    assign rr_ok[i]  = base_ok[i] && thr_ready[i];
    assign old_ok[i] = (base_ok[i] || st == ST_FTRAP) && thr_ready[i] && !thr_empty[i];
  end

  if (NTHR == 1) begin : g_one
    logic unused_in;
    assign unused_in   = ^{clk, rst_n, policy, thr_empty, thr_ready, thr_seq, grant_take, rr_ok};
    assign grant_valid = base_ok[0] || (thr_status[2:0] == ST_FTRAP);
    assign grant_idx   = '0;

    always_comb begin
      a_r10_single: assert (grant_valid == (thr_status[2:0] <= 3'd1 || thr_status[2:0] == 3'd4));
    end
  end else begin : g_multi
    logic [IDXW-1:0] lst [NTHR];
    logic            r_hit, o_hit;
    logic [IDXW-1:0] r_pos, r_idx, o_idx;
    logic [SEQW-1:0] o_seq;
    logic [NTHR-1:0] seen;
    logic            use_rr;

    assign use_rr = (policy == POL_RR);

    always_comb begin
      r_hit = 1'b0;
      r_pos = '0;
      r_idx = '0;
      for (int p = 0; p < NTHR; p++) begin
        if (!r_hit && rr_ok[lst[p]]) begin
          r_hit = 1'b1;
          r_pos = IDXW'(p);
          r_idx = lst[p];
        end
      end
    end

    always_comb begin
      o_hit = 1'b0;
      o_idx = '0;
      o_seq = '0;
      for (int i = 0; i < NTHR; i++) begin
        if (old_ok[i] && (!o_hit || thr_seq[SEQW*i +: SEQW] < o_seq)) begin
          o_hit = 1'b1;
          o_idx = IDXW'(i);
          o_seq = thr_seq[SEQW*i +: SEQW];
        end
      end
    end

    assign grant_valid = use_rr ? r_hit : o_hit;
    assign grant_idx   = use_rr ? r_idx : o_idx;

    // R1: ascending order out of reset; R4/R5: rotate only on a taken round-robin grant
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int p = 0; p < NTHR; p++) lst[p] <= IDXW'(p);
      end else if (grant_take && use_rr && r_hit) begin
        for (int p = 0; p < NTHR - 1; p++)
          if (p >= int'(r_pos)) lst[p] <= lst[p+1];
        lst[NTHR-1] <= r_idx;
      end
    end

    always_comb begin
      seen = '0;
      for (int p = 0; p < NTHR; p++) seen[lst[p]] = 1'b1;
    end

    a_r4_list_perm: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(seen) == NTHR);
    a_r4_winner_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_take && use_rr && grant_valid) |=> (lst[NTHR-1] == $past(grant_idx)));
    a_r5_hold_list: assert property (@(posedge clk) disable iff (!rst_n)
      (!(grant_take && use_rr)) |=> $stable(lst[0]) && $stable(lst[NTHR-1]));
    a_r2_rr_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      (use_rr && grant_valid) |-> thr_ready[grant_idx] && thr_status[3*grant_idx +: 3] <= 3'd1);
    a_r6_old_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      (!use_rr && grant_valid) |-> thr_ready[grant_idx] && !thr_empty[grant_idx]);
    a_r9_none: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_ready == '0) |-> !grant_valid && grant_idx == '0);
  end
endmodule

// File: tb/commit_arbiter_bench.sv
module commit_arbiter_bench;
  localparam int N = 4;
  localparam int SW = 6;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] policy;
  logic [3*N-1:0] st;
  logic [N-1:0] emp, rdy;
  logic [SW*N-1:0] seq;
  logic take;
  logic gv;
  logic [1:0] gi;

  logic [2:0] st1;
  logic gv1;
  logic gi1;

  int checks = 0, fails = 0;
  int mq [N];
  logic [31:0] rs = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  commit_arbiter #(.NTHR(N), .SEQW(SW)) u_commit_arbiter (
    .clk(clk), .rst_n(rst_n), .policy(policy), .thr_status(st), .thr_empty(emp),
    .thr_ready(rdy), .thr_seq(seq), .grant_take(take), .grant_valid(gv), .grant_idx(gi));

  commit_arbiter #(.NTHR(1), .SEQW(SW)) u_commit_arbiter_one (
    .clk(clk), .rst_n(rst_n), .policy(policy), .thr_status(st1), .thr_empty(emp[0]),
    .thr_ready(rdy[0]), .thr_seq(seq[SW-1:0]), .grant_take(take), .grant_valid(gv1), .grant_idx(gi1));

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  task automatic chk(input string tag, input logic av, input int ai, input logic ev, input int ei);
    checks++;
    if (av !== ev || (ev && ai != ei) || (!ev && ai != 0)) begin
      fails++;
      $display("FAIL %s: got valid=%0b idx=%0d expected valid=%0b idx=%0d", tag, av, ai, ev, ei);
    end
  endtask

  task automatic model(output logic ev, output int ei, output int epos);
    int s, best;
    ev = 0; ei = 0; epos = 0; best = 0;
    if (policy == 2'd1) begin
      for (int p = 0; p < N; p++) begin
        s = int'(st[3*mq[p] +: 3]);
        if (!ev && rdy[mq[p]] && s <= 1) begin ev = 1; ei = mq[p]; epos = p; end
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        s = int'(st[3*i +: 3]);
        if (!emp[i] && rdy[i] && (s <= 1 || s == 4) && (!ev || int'(seq[SW*i +: SW]) < best)) begin
          ev = 1; ei = i; best = int'(seq[SW*i +: SW]);
        end
      end
    end
  endtask

  task automatic step(input string tag);
    logic ev; int ei, ep;
    #1;
    model(ev, ei, ep);
    chk(tag, gv, int'(gi), ev, ei);
    if (take && ev && policy == 2'd1) begin
      for (int p = ep; p < N - 1; p++) mq[p] = mq[p+1];
      mq[N-1] = ei;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    policy = 2'd1; st = '0; emp = '0; rdy = '0; seq = '0; take = 0; st1 = 3'd0;
    for (int p = 0; p < N; p++) mq[p] = p;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: nothing ready
    step("R9");
    // R1: reset order, all eligible, round-robin grants thread 0
    rdy = '1;
    step("R1");
    // R4: take grants in turn, rotation gives 0,1,2,3,0
    take = 1;
    for (int k = 0; k < 5; k++) step("R4");
    take = 0;
    // R2: empty ignored, fetch-trap excluded under round-robin
    emp = '1; st = {3'd4, 3'd4, 3'd1, 3'd4};
    step("R2");
    // R6: same inputs under oldest-first, empty blocks all
    policy = 2'd2;
    step("R6");
    emp = '0; seq = {6'd5, 6'd9, 6'd9, 6'd20};
    step("R6");
    // R7: tie between equal sequence numbers picks lowest index
    st = '0; seq = {6'd9, 6'd3, 6'd3, 6'd9};
    step("R7");
    // R8: aggressive and code 3 match oldest-first
    policy = 2'd0; step("R8");
    policy = 2'd3; step("R8");
    // R5: take under oldest-first, then round-robin must follow the unchanged list
    take = 1; policy = 2'd2; step("R5");
    take = 0; policy = 2'd1; st = '0; rdy = '1; step("R5");

    // sweep over many patterns and all policies
    for (int pol = 0; pol < 4; pol++) begin
      for (int v = 0; v < 600; v++) begin
        rs = nxt(rs); policy = (v % 3 == 0) ? 2'(pol) : 2'(rs[31:30] == 2'd0 ? 1 : pol);
        for (int i = 0; i < N; i++) st[3*i +: 3] = 3'(rs[3*i +: 4] % 6);
        rs = nxt(rs); rdy = rs[3:0] | rs[7:4]; emp = rs[11:8] & rs[15:12];
        seq = SW*N'(rs[31:8] & {(SW*N){rs[5]}} | (rs[23:0] & 24'h0f0f0f));
        take = rs[2];
        step(policy == 2'd1 ? "R3" : "R7");
      end
    end
    take = 0;

    // R10: single-thread instance, every status code, ready held low
    rdy = '0; emp = '1;
    for (int pol = 0; pol < 4; pol++)
      for (int s = 0; s < 8; s++) begin
        policy = 2'(pol); st1 = 3'(s);
        #1;
        chk("R10", gv1, int'(gi1), (s <= 1 || s == 4), 0);
        @(negedge clk);
      end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule